// File: doc/BRIEF.md
# Layer Sequencer for a Seven-Stage Inference Engine

This block is the control machine of a co-processing inference engine. A host programs a small table of per-layer transfer lengths and places the input image in scratch RAM A. It then sets a start bit. From that point the sequencer steps through seven layers in a fixed kind order: convolution, pooling, convolution, pooling, convolution, fully connected, fully connected. For each layer it tells the arithmetic stage which mode to use. It streams read addresses into the current source scratch RAM and streams write addresses into the other one. In convolution and fully connected layers it also advances running addresses into the weight and bias memories.

The two scratch RAMs trade places at every layer boundary. Seven is odd, so the last layer leaves its outputs in scratch RAM B. The sequencer then reads the ten class scores back from RAM B and keeps the index of the largest one. After that it raises a sticky interrupt and holds the number of cycles the run took.

Top module: `lseq_top`

## Requirements
- R1: Configuration writes use `cfg_addr`. Value `{0,L}` (bit 3 clear, L in 0..6) sets the read length of layer L. Value `{1,L}` sets its write length. Value 4'hF is the control word: bit 0 is start and bit 1 is interrupt clear. Every length must be at least 1, and each length is 1 after reset.
- R2: A start written while idle makes `busy` high in the next cycle. The run begins at layer 0 with `src_sel`=0 (RAM A is the source). The cycle count restarts and the interrupt is cleared.
- R3: Each layer first runs a read phase of exactly its read length in cycles, with `rd_addr` counting 0,1,2,... Then it runs a write phase of exactly its write length, with `wr_addr` counting 0,1,2,... `rd_en` and `wr_en` are never high in the same cycle.
- R4: `layer_mode` follows the layer index. It is 0 (convolution) for layers 0, 2 and 4, 1 (pooling) for layers 1 and 3, and 2 (fully connected) for layers 5 and 6.
- R5: `src_sel` inverts at every layer boundary. Writes always go to the RAM not selected by `src_sel`.
- R6: `wt_addr` starts at 0 on each run and advances by one in every read cycle of a convolution or fully connected layer. `bias_addr` works the same way in write cycles. Pooling layers assert neither `wt_en` nor `bias_en`.
- R7: After layer 6 the sequencer issues NCLASS reads (addresses 0..NCLASS-1) with `src_sel`=1 (RAM B). It takes `res_data` one cycle after each read. One further busy cycle follows with no read.
- R8: `class_idx` is the index of the largest signed value among the scores read back. On a tie the lower index wins.
- R9: At the end of a run `busy` drops and `irq` rises in the same cycle. `irq` stays high until a control write with bit 1 set, or a new start.
- R10: `cycle_count` equals the number of busy cycles of the run: the sum of all read and write lengths, plus NCLASS, plus one. It holds that value while idle.
- R11: A start written while `busy` is high is ignored. The run continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register select |
| cfg_wdata | input | LW | Configuration write data |
| res_data | input | DW | Signed score read from scratch RAM B |
| busy | output | 1 | Run in progress |
| irq | output | 1 | Sticky completion interrupt |
| layer_idx | output | 3 | Current layer number |
| layer_mode | output | 2 | Arithmetic stage mode for the current layer |
| src_sel | output | 1 | Source scratch RAM: 0 = A, 1 = B |
| rd_en | output | 1 | Scratch read strobe |
| rd_addr | output | AW | Scratch read address |
| wr_en | output | 1 | Scratch write strobe |
| wr_addr | output | AW | Scratch write address |
| wt_en | output | 1 | Weight memory read strobe |
| wt_addr | output | WAW | Weight memory address |
| bias_en | output | 1 | Bias memory read strobe |
| bias_addr | output | BAW | Bias memory address |
| class_idx | output | CIW | Predicted class |
| cycle_count | output | CW | Busy cycles of the last run |

## Verification
A wrong phase counter or layer index appears at once. The scratch addresses run out of order, or the mode changes one cycle early or late, in the first cycle where the phase should have ended. A missed buffer swap points the very next layer at the wrong RAM. The final read-back then comes from RAM A, so the wrong scores are read and the class comes out wrong at the interrupt. Errors in the weight and bias pointers build up across layers and show on the next convolution or fully connected cycle. A lost or extra busy cycle shifts the held cycle count by exactly that amount.

// File: rtl/lseq_pkg.sv
package lseq_pkg;
  localparam int NUM_LAYERS = 7;
  localparam logic [3:0] CTRL_ADDR = 4'hF;

  typedef enum logic [1:0] {
    MODE_CONV = 2'd0,
    MODE_POOL = 2'd1,
    MODE_FC   = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_WR, ST_ARG, ST_ARGW
  } state_e;

  function automatic mode_e mode_of(input logic [2:0] idx);
    case (idx)
      3'd1, 3'd3: mode_of = MODE_POOL;
      3'd5, 3'd6: mode_of = MODE_FC;
      default:    mode_of = MODE_CONV;
    endcase
  endfunction
endpackage

// File: rtl/lseq_dimtab.sv
module lseq_dimtab
  import lseq_pkg::*;
#(
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [3:0]    addr,
  input  logic [LW-1:0] wdata,
  input  logic [2:0]    sel_layer,
  output logic [LW-1:0] rd_len,
  output logic [LW-1:0] wr_len
);
  logic [LW-1:0] rd_tab [NUM_LAYERS];
  logic [LW-1:0] wr_tab [NUM_LAYERS];

  for (genvar g = 0; g < NUM_LAYERS; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_tab[g] <= LW'(1);
        wr_tab[g] <= LW'(1);
      end else if (we && addr[2:0] == 3'(g)) begin
        if (addr[3]) wr_tab[g] <= wdata;
        else         rd_tab[g] <= wdata;
      end
    end
  end

  always_comb begin
    rd_len = LW'(1);
    wr_len = LW'(1);
    if (int'(sel_layer) < NUM_LAYERS) begin
      rd_len = rd_tab[sel_layer];
      wr_len = wr_tab[sel_layer];
    end
  end

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_len != '0) && (wr_len != '0)) else $error("zero length"); // R1
endmodule

// File: rtl/lseq_argmax.sv
module lseq_argmax #(
  parameter int DW     = 12,
  parameter int NCLASS = 10,
  parameter int CIW    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 in_valid,
  input  logic [CIW-1:0]       in_idx,
  input  logic signed [DW-1:0] in_data,
  output logic [CIW-1:0]       best_idx
);
  logic signed [DW-1:0] best_val;

  function automatic logic beats(input logic signed [DW-1:0] cand,
                                 input logic signed [DW-1:0] held);
    beats = cand > held;
  endfunction

  wire take = in_valid && (in_idx == '0 || beats(in_data, best_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_val <= '0;
      best_idx <= '0;
    end else if (clear) begin
      best_val <= '0;
      best_idx <= '0;
    end else if (take) begin
      best_val <= in_data;
      best_idx <= in_idx;
    end
  end

  AST_CLASS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(best_idx) < NCLASS) else $error("class out of range"); // R8
  AST_TIE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_idx != '0 && in_data == best_val && !clear) |=> $stable(best_idx))
    else $error("tie replaced lower index"); // R8
endmodule

// File: rtl/lseq_top.sv
module lseq_top
  import lseq_pkg::*;
#(
  parameter int DW     = 12,
  parameter int AW     = 10,
  parameter int LW     = AW + 1,
  parameter int WAW    = 16,
  parameter int BAW    = 9,
  parameter int CW     = 20,
  parameter int NCLASS = 10,
  parameter int CIW    = $clog2(NCLASS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [3:0]           cfg_addr,
  input  logic [LW-1:0]        cfg_wdata,
  input  logic signed [DW-1:0] res_data,
  output logic                 busy,
  output logic                 irq,
  output logic [2:0]           layer_idx,
  output logic [1:0]           layer_mode,
  output logic                 src_sel,
  output logic                 rd_en,
  output logic [AW-1:0]        rd_addr,
  output logic                 wr_en,
  output logic [AW-1:0]        wr_addr,
  output logic                 wt_en,
  output logic [WAW-1:0]       wt_addr,
  output logic                 bias_en,
  output logic [BAW-1:0]       bias_addr,
  output logic [CIW-1:0]       class_idx,
  output logic [CW-1:0]        cycle_count
);
  localparam logic [2:0]    LAST_LAYER = 3'(NUM_LAYERS - 1);
  localparam logic [LW-1:0] LAST_CLASS = LW'(NCLASS - 1);

  state_e        state;
  logic [LW-1:0] cnt;
  logic [LW-1:0] rd_len, wr_len;
  logic          arg_vld;
  logic [CIW-1:0] arg_idx;

  // named internal events
  wire start_req  = cfg_we && cfg_addr == CTRL_ADDR && cfg_wdata[0];
  wire clear_req  = cfg_we && cfg_addr == CTRL_ADDR && cfg_wdata[1];
  wire start_ok   = start_req && state == ST_IDLE;
  wire has_params = layer_mode != MODE_POOL;
  wire rd_last    = state == ST_RD  && cnt == rd_len - LW'(1);
  wire wr_last    = state == ST_WR  && cnt == wr_len - LW'(1);
  wire arg_last   = state == ST_ARG && cnt == LAST_CLASS;

  lseq_dimtab #(.LW(LW)) u_tab (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .sel_layer(layer_idx), .rd_len(rd_len), .wr_len(wr_len)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      layer_idx   <= '0;
      src_sel     <= 1'b0;
      wt_addr     <= '0;
      bias_addr   <= '0;
      cycle_count <= '0;
      irq         <= 1'b0;
    end else begin
      if (state != ST_IDLE) cycle_count <= cycle_count + CW'(1);
      case (state)
        ST_IDLE: begin
          if (start_ok) begin
            state       <= ST_RD;
            cnt         <= '0;
            layer_idx   <= '0;
            src_sel     <= 1'b0;
            wt_addr     <= '0;
            bias_addr   <= '0;
            cycle_count <= '0;
            irq         <= 1'b0;
          end else if (clear_req) begin
            irq <= 1'b0;
          end
        end
        ST_RD: begin
          if (has_params) wt_addr <= wt_addr + WAW'(1);
          if (rd_last) begin
            cnt   <= '0;
            state <= ST_WR;
          end else cnt <= cnt + LW'(1);
        end
        ST_WR: begin
          if (has_params) bias_addr <= bias_addr + BAW'(1);
          if (wr_last) begin
            cnt     <= '0;
            src_sel <= ~src_sel;
            if (layer_idx == LAST_LAYER) state <= ST_ARG;
            else begin
              layer_idx <= layer_idx + 3'd1;
              state     <= ST_RD;
            end
          end else cnt <= cnt + LW'(1);
        end
        ST_ARG: begin
          if (arg_last) begin
            cnt   <= '0;
            state <= ST_ARGW;
          end else cnt <= cnt + LW'(1);
        end
        ST_ARGW: begin
          state <= ST_IDLE;
          irq   <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arg_vld <= 1'b0;
      arg_idx <= '0;
    end else begin
      arg_vld <= state == ST_ARG;
      arg_idx <= cnt[CIW-1:0];
    end
  end

  lseq_argmax #(.DW(DW), .NCLASS(NCLASS), .CIW(CIW)) u_arg (
    .clk(clk), .rst_n(rst_n), .clear(start_ok), .in_valid(arg_vld),
    .in_idx(arg_idx), .in_data(res_data), .best_idx(class_idx)
  );

  always_comb begin
    busy       = state != ST_IDLE;
    layer_mode = mode_of(layer_idx);
    rd_en      = state == ST_RD || state == ST_ARG;
    rd_addr    = cnt[AW-1:0];
    wr_en      = state == ST_WR;
    wr_addr    = cnt[AW-1:0];
    wt_en      = state == ST_RD && has_params;
    bias_en    = state == ST_WR && has_params;
  end

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en)) else $error("read and write together"); // R3
  AST_POOL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && layer_mode == MODE_POOL) |-> (!wt_en && !bias_en)) else $error("pool touched params"); // R6
  AST_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && layer_idx != $past(layer_idx)) |-> (src_sel != $past(src_sel)))
    else $error("no buffer swap"); // R5
  AST_BUSY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> cycle_count == $past(cycle_count) + CW'(1)) else $error("count broke"); // R10 R11
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy) else $error("irq while busy"); // R9
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !cfg_we) |=> irq) else $error("irq dropped"); // R9
endmodule

// File: tb/lseq_top_tb.sv
`timescale 1ns/1ps
module lseq_top_tb;
  localparam int DW = 12, AW = 10, LW = 11, WAW = 16, BAW = 9, CW = 20, NC = 10, CIW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [LW-1:0] cfg_wdata = '0;
  logic signed [DW-1:0] res_data = '0;
  logic busy, irq, src_sel, rd_en, wr_en, wt_en, bias_en;
  logic [2:0] layer_idx;
  logic [1:0] layer_mode;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [WAW-1:0] wt_addr;
  logic [BAW-1:0] bias_addr;
  logic [CIW-1:0] class_idx;
  logic [CW-1:0] cycle_count;

  int vectors = 0, fails = 0;
  logic signed [DW-1:0] scores [NC];

  always #2.5 clk = ~clk;

  lseq_top u_dut (.*);

  // RAM B model: synchronous read, one cycle latency
  always @(posedge clk) if (rd_en && src_sel && int'(rd_addr) < NC) res_data <= scores[rd_addr];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = LW'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input int rl[7], input int wl[7], input int sc[NC], input bit poke);
    int wp = 0, bp = 0, src = 0, total = 0, best = 0, m;
    for (int l = 0; l < 7; l++) begin
      cfg_write({1'b0, 3'(l)}, rl[l]);   // R1 read length slot
      cfg_write({1'b1, 3'(l)}, wl[l]);   // R1 write length slot
      total += rl[l] + wl[l];
    end
    for (int i = 0; i < NC; i++) begin
      scores[i] = DW'(sc[i]);
      if (sc[i] > sc[best]) best = i;
    end
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'hF; cfg_wdata = LW'(1);
    for (int l = 0; l < 7; l++) begin
      m = (l == 1 || l == 3) ? 1 : (l >= 5 ? 2 : 0);
      for (int c = 0; c < rl[l]; c++) begin
        @(negedge clk); cfg_we = 1'b0;
        chk(busy && int'(layer_idx) == l, "R2", layer_idx, l);
        chk(int'(layer_mode) == m, "R4", layer_mode, m);
        chk(int'(src_sel) == src, "R5", src_sel, src);
        chk(rd_en && !wr_en && int'(rd_addr) == c, "R3", rd_addr, c);
        chk(wt_en == (m != 1), "R6", wt_en, m != 1);
        if (m != 1) begin chk(int'(wt_addr) == wp, "R6", wt_addr, wp); wp++; end
        if (poke && l == 2 && c == 0) begin
          cfg_we = 1'b1; cfg_addr = 4'hF; cfg_wdata = LW'(1);  // R11 start while busy
        end
      end
      for (int c = 0; c < wl[l]; c++) begin
        @(negedge clk); cfg_we = 1'b0;
        chk(wr_en && !rd_en && int'(wr_addr) == c, "R3", wr_addr, c);
        chk(int'(src_sel) == src, "R5", src_sel, src);
        chk(int'(layer_mode) == m, "R4", layer_mode, m);
        chk(bias_en == (m != 1), "R6", bias_en, m != 1);
        if (m != 1) begin chk(int'(bias_addr) == bp, "R6", bias_addr, bp); bp++; end
      end
      src = 1 - src;
    end
    for (int c = 0; c < NC; c++) begin
      @(negedge clk);
      chk(rd_en && src_sel && int'(rd_addr) == c, "R7", rd_addr, c);
    end
    @(negedge clk);
    chk(busy && !rd_en && !irq, "R7", rd_en, 0);
    @(negedge clk);
    chk(!busy && irq, "R9", irq, 1);
    chk(int'(class_idx) == best, "R8", class_idx, best);
    chk(int'(cycle_count) == total + NC + 1, "R10", cycle_count, total + NC + 1);
    repeat (3) @(negedge clk);
    chk(irq && int'(cycle_count) == total + NC + 1, "R9 R10 hold", cycle_count, total + NC + 1);
    cfg_write(4'hF, 2);
    chk(!irq && !busy, "R9 clear", irq, 0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !irq && !rd_en && !wr_en && cycle_count == '0, "R2 reset", busy, 0);
    run('{2,1,3,1,2,4,3}, '{3,2,1,2,2,3,1}, '{1,2,3,4,5,6,7,8,9,10}, 1'b0);
    run('{1,1,1,1,1,1,1}, '{1,1,1,1,1,1,1}, '{-5,-3,-9,40,-1,0,7,40,-2,-8}, 1'b1);
    run('{5,2,4,3,1,2,2}, '{1,4,2,1,3,1,5}, '{6,6,6,6,6,6,6,6,6,6}, 1'b0);
    run('{3,3,2,2,1,1,4}, '{2,2,3,3,4,4,1}, '{-1,-100,-50,-2,-3,-4,-5,-6,-7,-2048}, 1'b0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule